// File: doc/BRIEF.md
# Double-Buffered Serial Transmitter with Status Flags

This block is the transmit half of an asynchronous serial port. A character written by the host goes into a holding register. When the shift register is free, the character moves into it and is sent on the line. The host can therefore queue the next character while the current one is still being shifted. Each character is framed as a low start bit, 8 or 9 data bits sent LSB first, and a high stop bit. When hardware parity is on, the ninth bit carries the computed parity. A break request holds the line low for whole frame times. After a break, the line goes high for at least one bit time before any character is sent.

Two flags report progress to the host. The "buffer empty" flag means a new character may be written. The "transmission complete" flag means nothing is queued, shifting or requested. Each flag has its own interrupt enable. A small pin-control stage sets the direction of the transmit pin and chooses the receiver's input: the receive pin, an internal loopback from the transmitter, or the transmit pin itself in single-wire mode. Bit timing comes from an external tick running at 16 times the bit rate.

Top module: `uart_dbuf_tx`

## Requirements
- R1: `txd` is high whenever no frame or break is being sent. After reset, `txd`=1, `tdre`=1 and `tc`=1.
- R2: With `nine_bit`=0 and `par_en`=0, a frame is one start bit (0), then `wr_data[7:0]` LSB first, then one stop bit (1). Each bit lasts 16 `bit_tick` pulses.
- R3: With `nine_bit`=1 and `par_en`=0, `wr_data[8]` is sent as a ninth data bit after bit 7 and before the stop bit.
- R4: With `par_en`=1, the 9-bit frame is used and the ninth bit is a parity bit. It is the XOR of `wr_data[7:0]` when `par_odd`=0 (even parity) and the inverse of that XOR when `par_odd`=1 (odd parity).
- R5: A write (`wr_en`=1) clears `tdre` at the next clock edge. If the shifter is free, the character moves to the shifter at the following edge: `tdre` returns to 1 and `txd` drops to the start bit at that same edge.
- R6: A character written while another is being shifted starts its start bit directly after the previous stop bit, with no idle time between the frames.
- R7: `tc` is cleared by a write and is 0 while a frame or a break is in progress. It is 1 only when the holding register is empty, the shifter is idle and no break is requested.
- R8: While `brk_req`=1, `txd` is driven low in whole frame times (10 bit times for 8-bit frames). Break frames repeat back to back for as long as the request is held.
- R9: When a break frame ends with `brk_req`=0, `txd` is high for one bit time before any queued character starts.
- R10: `tdre_irq` is `tdre` gated by `tdre_ie`, and `tc_irq` is `tc` gated by `tc_ie`.
- R11: `txd_oe` is 1 except in single-wire mode (`loop_en`=1 and `loop_sel`=1) with `pin_dir`=0, where it is 0. It is registered, so it follows the controls one clock later.
- R12: `rx_src` is registered one clock after its source. The source is `rxd_i` when `loop_en`=0, the transmitter output `txd` when `loop_en`=1 and `loop_sel`=0, and the pin input `txd_pin_i` in single-wire mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bit_tick | input | 1 | One-cycle pulse at 16 times the bit rate |
| wr_en | input | 1 | Write strobe for the holding register |
| wr_data | input | 9 | Character to send; bit 8 is the ninth bit |
| nine_bit | input | 1 | Send 9 data bits |
| par_en | input | 1 | Replace the ninth bit with parity |
| par_odd | input | 1 | Odd parity when 1, even when 0 |
| brk_req | input | 1 | Request break frames |
| loop_en | input | 1 | Loop mode: the receiver does not take its input from rxd_i |
| loop_sel | input | 1 | In loop mode, 1 selects single-wire operation |
| pin_dir | input | 1 | Single-wire pin direction, 1 = output |
| tdre_ie | input | 1 | Buffer-empty interrupt enable |
| tc_ie | input | 1 | Complete interrupt enable |
| rxd_i | input | 1 | Receive pin |
| txd_pin_i | input | 1 | Value seen on the transmit pin |
| txd | output | 1 | Transmit data |
| txd_oe | output | 1 | Output enable of the transmit pin |
| rx_src | output | 1 | Serial input for the receiver |
| tdre | output | 1 | Holding register empty |
| tc | output | 1 | Transmission complete |
| tdre_irq | output | 1 | Buffer-empty interrupt request |
| tc_irq | output | 1 | Complete interrupt request |

## Verification
The bench queues a second character as soon as the buffer frees and decodes both frames as one 20-bit stream. A design that idles between frames, or that drops or repeats a character, shifts every later bit out of place. It holds a break across the boundary between two break frames, with a character queued during the break, and then times the high gap before that character. A design that leaves out the stop-level bit after a break, ends the break early or sends the queued character in the middle of the break gets the low or high duration wrong. Parity is checked with both sets of odd and even data, so a parity bit that is inverted or always the same is caught. The bench also drives the receive pin and an external line on the transmit pin while switching between the three receiver sources. A wrong multiplexer or direction bit then shows up on `rx_src` or `txd_oe`.

// File: rtl/uart_dbuf_tx_pkg.sv
package uart_dbuf_tx_pkg;
  // what the shifter loads on a given cycle
  typedef enum logic [1:0] {LD_NONE, LD_DATA, LD_BRK, LD_TAIL} load_e;
  // receiver input selection
  typedef enum logic [1:0] {RXS_PIN, RXS_LOOP, RXS_WIRE} rxsel_e;
endpackage

// File: rtl/uart_dbuf_tx_hold.sv
module uart_dbuf_tx_hold #(
  parameter int W = 9
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  input  logic         take,
  output logic         full,
  output logic [W-1:0] data,
  output logic         empty_flag
);
  always_ff @(posedge clk) begin
    if (rst) begin
      full       <= 1'b0;
      empty_flag <= 1'b1;
      data       <= '0;
    end else if (wr_en) begin
      full       <= 1'b1;
      empty_flag <= 1'b0;
      data       <= wr_data;
    end else if (take) begin
      full       <= 1'b0;
      empty_flag <= 1'b1;
    end
  end
endmodule

// File: rtl/uart_dbuf_tx_shift.sv
module uart_dbuf_tx_shift
  import uart_dbuf_tx_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int OVS    = 16
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            bit_tick,
  input  logic            buf_full,
  input  logic [DATA_W:0] buf_data,
  input  logic            nine_bit,
  input  logic            par_en,
  input  logic            par_odd,
  input  logic            brk_req,
  output logic            take,
  output logic            busy,
  output logic            txd
);
  localparam int FW = DATA_W + 3;          // start + data + ninth + stop
  localparam int LW = $clog2(FW + 1);
  localparam int CW = $clog2(OVS);

  logic [FW-1:0] sh;
  logic [LW-1:0] left;
  logic [CW-1:0] sub;
  logic          brk_q;
  logic          wide, ninth, bit_end, last, free;
  logic [LW-1:0] nbits;
  load_e         kind;

  assign wide    = nine_bit | par_en;
  assign nbits   = wide ? LW'(FW) : LW'(FW - 1);
  assign ninth   = par_en ? ((^buf_data[DATA_W-1:0]) ^ par_odd) : buf_data[DATA_W];
  assign busy    = (left != '0);
  assign bit_end = busy && bit_tick && (sub == CW'(OVS - 1));
  assign last    = bit_end && (left == LW'(1));
  assign free    = !busy || last;

  always_comb begin
    kind = LD_NONE;
    if (last && brk_q)         kind = brk_req ? LD_BRK : LD_TAIL;
    else if (free && buf_full) kind = LD_DATA;
    else if (free && brk_req)  kind = LD_BRK;
  end

  assign take = (kind == LD_DATA);
  assign txd  = sh[0];

  always_ff @(posedge clk) begin
    if (rst) begin
      sh    <= '1;
      left  <= '0;
      sub   <= '0;
      brk_q <= 1'b0;
    end else begin
      case (kind)
        LD_DATA: begin
          sh    <= {1'b1, (wide ? ninth : 1'b1), buf_data[DATA_W-1:0], 1'b0};
          left  <= nbits;
          sub   <= '0;
          brk_q <= 1'b0;
        end
        LD_BRK: begin
          // zeros for the frame length, ones above so the line ends high
          sh    <= wide ? '0 : {1'b1, {(FW-1){1'b0}}};
          left  <= nbits;
          sub   <= '0;
          brk_q <= 1'b1;
        end
        LD_TAIL: begin
          sh    <= '1;
          left  <= LW'(1);
          sub   <= '0;
          brk_q <= 1'b0;
        end
        default: begin
          if (bit_end) begin
            sh   <= {1'b1, sh[FW-1:1]};
            left <= left - LW'(1);
            sub  <= '0;
          end else if (busy && bit_tick) begin
            sub  <= sub + CW'(1);
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/uart_dbuf_tx_pin.sv
module uart_dbuf_tx_pin
  import uart_dbuf_tx_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic loop_en,
  input  logic loop_sel,
  input  logic pin_dir,
  input  logic rxd_i,
  input  logic txd_pin_i,
  input  logic txd,
  output logic txd_oe,
  output logic rx_src
);
  rxsel_e sel;

  always_comb begin
    if (!loop_en)      sel = RXS_PIN;
    else if (loop_sel) sel = RXS_WIRE;
    else               sel = RXS_LOOP;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      txd_oe <= 1'b1;
      rx_src <= 1'b1;
    end else begin
      txd_oe <= (sel != RXS_WIRE) || pin_dir;
      case (sel)
        RXS_LOOP: rx_src <= txd;
        RXS_WIRE: rx_src <= txd_pin_i;
        default:  rx_src <= rxd_i;
      endcase
    end
  end
endmodule

// File: rtl/uart_dbuf_tx.sv
module uart_dbuf_tx #(
  parameter int DATA_W = 8,
  parameter int OVS    = 16
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            bit_tick,
  input  logic            wr_en,
  input  logic [DATA_W:0] wr_data,
  input  logic            nine_bit,
  input  logic            par_en,
  input  logic            par_odd,
  input  logic            brk_req,
  input  logic            loop_en,
  input  logic            loop_sel,
  input  logic            pin_dir,
  input  logic            tdre_ie,
  input  logic            tc_ie,
  input  logic            rxd_i,
  input  logic            txd_pin_i,
  output logic            txd,
  output logic            txd_oe,
  output logic            rx_src,
  output logic            tdre,
  output logic            tc,
  output logic            tdre_irq,
  output logic            tc_irq
);
  logic            buf_full, take, busy;
  logic [DATA_W:0] buf_data;

  uart_dbuf_tx_hold #(.W(DATA_W + 1)) u_hold (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data), .take(take),
    .full(buf_full), .data(buf_data), .empty_flag(tdre)
  );

  uart_dbuf_tx_shift #(.DATA_W(DATA_W), .OVS(OVS)) u_shift (
    .clk(clk), .rst(rst), .bit_tick(bit_tick), .buf_full(buf_full),
    .buf_data(buf_data), .nine_bit(nine_bit), .par_en(par_en),
    .par_odd(par_odd), .brk_req(brk_req), .take(take), .busy(busy), .txd(txd)
  );

  uart_dbuf_tx_pin u_pin (
    .clk(clk), .rst(rst), .loop_en(loop_en), .loop_sel(loop_sel),
    .pin_dir(pin_dir), .rxd_i(rxd_i), .txd_pin_i(txd_pin_i), .txd(txd),
    .txd_oe(txd_oe), .rx_src(rx_src)
  );

  // complete: nothing queued, nothing shifting, no break wanted
  always_ff @(posedge clk) begin
    if (rst) tc <= 1'b1;
    else     tc <= !wr_en && !buf_full && !busy && !brk_req;
  end

  assign tdre_irq = tdre & tdre_ie;
  assign tc_irq   = tc & tc_ie;
endmodule

// File: rtl/uart_dbuf_tx_chk.sv
module uart_dbuf_tx_chk (
  input logic clk,
  input logic rst,
  input logic wr_en,
  input logic brk_req,
  input logic loop_en,
  input logic loop_sel,
  input logic pin_dir,
  input logic tdre_ie,
  input logic tc_ie,
  input logic txd,
  input logic txd_oe,
  input logic tdre,
  input logic tc,
  input logic tdre_irq,
  input logic tc_irq
);
  assert_idle_high_R1: assert property (@(posedge clk) disable iff (rst)
    tc |-> txd);

  assert_write_clears_R5: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> !tdre);

  assert_start_on_transfer_R5: assert property (@(posedge clk) disable iff (rst)
    $rose(tdre) |-> !txd);

  assert_write_clears_tc_R7: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> !tc);

  assert_break_clears_tc_R7: assert property (@(posedge clk) disable iff (rst)
    brk_req |=> !tc);

  assert_irq_gate_R10: assert property (@(posedge clk) disable iff (rst)
    (!tdre_ie |-> !tdre_irq) and (!tc_ie |-> !tc_irq));

  assert_pin_input_R11: assert property (@(posedge clk) disable iff (rst)
    (loop_en && loop_sel && !pin_dir) |=> !txd_oe);

  assert_pin_output_R11: assert property (@(posedge clk) disable iff (rst)
    !loop_en |=> txd_oe);
endmodule

bind uart_dbuf_tx uart_dbuf_tx_chk u_chk (.*);

// File: tb/uart_dbuf_tx_test.sv
module uart_dbuf_tx_test;
  logic clk = 1'b0;
  logic rst, bit_tick, wr_en;
  logic [8:0] wr_data;
  logic nine_bit, par_en, par_odd, brk_req, loop_en, loop_sel, pin_dir;
  logic tdre_ie, tc_ie, rxd_i, ext_line;
  logic txd_pin_i, txd, txd_oe, rx_src, tdre, tc, tdre_irq, tc_irq;
  int errors = 0;
  int checks = 0;

  always #2 clk = ~clk;  // 250 MHz

  assign txd_pin_i = txd_oe ? txd : ext_line;

  uart_dbuf_tx uut (
    .clk(clk), .rst(rst), .bit_tick(bit_tick), .wr_en(wr_en), .wr_data(wr_data),
    .nine_bit(nine_bit), .par_en(par_en), .par_odd(par_odd), .brk_req(brk_req),
    .loop_en(loop_en), .loop_sel(loop_sel), .pin_dir(pin_dir),
    .tdre_ie(tdre_ie), .tc_ie(tc_ie), .rxd_i(rxd_i), .txd_pin_i(txd_pin_i),
    .txd(txd), .txd_oe(txd_oe), .rx_src(rx_src), .tdre(tdre), .tc(tc),
    .tdre_irq(tdre_irq), .tc_irq(tc_irq)
  );

  // one tick every 4 clocks: one bit = 64 clocks
  initial begin
    bit_tick = 1'b0;
    forever begin
      repeat (3) @(negedge clk);
      bit_tick = 1'b1;
      @(negedge clk);
      bit_tick = 1'b0;
    end
  end

  initial begin
    #(4 * 150000);
    errors++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic write_char(input logic [8:0] d);
    wr_data = d;
    wr_en   = 1'b1;
    @(negedge clk);
    wr_en   = 1'b0;
  endtask

  // decode n line bits starting at the next start bit, sampled mid-bit
  task automatic grab(input int n, output logic [31:0] bits);
    int guard = 0;
    bits = '0;
    while (txd !== 1'b0 && guard < 5000) begin
      @(negedge clk);
      guard++;
    end
    repeat (30) @(negedge clk);
    for (int i = 0; i < n; i++) begin
      bits[i] = txd;
      if (i < n - 1) repeat (64) @(negedge clk);
    end
  endtask

  task automatic wait_done();
    int guard = 0;
    while (tc !== 1'b1 && guard < 5000) begin
      @(negedge clk);
      guard++;
    end
  endtask

  task automatic t_reset();
    rst = 1'b1;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R1", "txd after reset", txd, 1);
    check("R1", "tdre after reset", tdre, 1);
    check("R1", "tc after reset", tc, 1);
    check("R11", "txd_oe after reset", txd_oe, 1);
    check("R10", "tdre_irq masked", tdre_irq, 0);
  endtask

  task automatic t_frame8(input logic [7:0] d);
    logic [31:0] bits;
    write_char({1'b0, d});
    check("R5", "tdre cleared by write", tdre, 0);
    check("R7", "tc cleared by write", tc, 0);
    @(negedge clk);
    check("R5", "tdre set on transfer", tdre, 1);
    check("R5", "start bit on transfer", txd, 0);
    grab(10, bits);
    check("R2", "8-bit frame", bits[9:0], {1'b1, d, 1'b0});
    check("R7", "tc during stop bit", tc, 0);
    repeat (40) @(negedge clk);
    check("R7", "tc after frame", tc, 1);
    check("R1", "txd idle after frame", txd, 1);
  endtask

  task automatic t_nine(input logic [8:0] d);
    logic [31:0] bits;
    nine_bit = 1'b1;
    write_char(d);
    grab(11, bits);
    check("R3", "9-bit frame", bits[10:0], {1'b1, d, 1'b0});
    wait_done();
    nine_bit = 1'b0;
  endtask

  task automatic t_parity(input logic [7:0] d, input logic odd);
    logic [31:0] bits;
    par_en  = 1'b1;
    par_odd = odd;
    write_char({1'b1, d});  // bit 8 must be replaced by parity
    grab(11, bits);
    check("R4", "parity frame", bits[10:0], {1'b1, (^d) ^ odd, d, 1'b0});
    wait_done();
    par_en  = 1'b0;
    par_odd = 1'b0;
  endtask

  task automatic t_back_to_back(input logic [7:0] a, input logic [7:0] b);
    logic [31:0] bits;
    write_char({1'b0, a});
    @(negedge clk);
    check("R5", "tdre free for second char", tdre, 1);
    write_char({1'b0, b});
    check("R6", "tdre held while queued", tdre, 0);
    check("R7", "tc while queued", tc, 0);
    grab(20, bits);
    check("R6", "two frames without gap", bits[19:0],
          {1'b1, b, 1'b0, 1'b1, a, 1'b0});
    repeat (40) @(negedge clk);
    check("R7", "tc after both frames", tc, 1);
  endtask

  task automatic t_break();
    logic [31:0] bits;
    int lo = 0;
    int hi = 0;
    brk_req = 1'b1;
    @(negedge clk);
    check("R8", "break starts low", txd, 0);
    while (txd === 1'b0 && lo < 3000) begin
      @(negedge clk);
      lo++;
      if (lo == 50)  check("R7", "tc during break", tc, 0);
      if (lo == 100) begin wr_data = 9'h0C3; wr_en = 1'b1; end
      if (lo == 101) wr_en = 1'b0;
      if (lo == 700) brk_req = 1'b0;
    end
    // two full break frames of 640 clocks each, first aligned to a tick
    check("R8", "break low length in range", (lo >= 1270 && lo <= 1282), 1);
    while (txd === 1'b1 && hi < 500) begin
      @(negedge clk);
      hi++;
    end
    check("R9", "high bit after break", (hi >= 60 && hi <= 66), 1);
    grab(10, bits);
    check("R9", "queued char after break", bits[9:0], {1'b1, 8'hC3, 1'b0});
    wait_done();
  endtask

  task automatic t_irq();
    tdre_ie = 1'b1;
    tc_ie   = 1'b0;
    @(negedge clk);
    check("R10", "tdre_irq enabled", tdre_irq, 1);
    check("R10", "tc_irq masked", tc_irq, 0);
    tc_ie = 1'b1;
    @(negedge clk);
    check("R10", "tc_irq enabled", tc_irq, 1);
    write_char(9'h05A);
    check("R10", "tdre_irq after write", tdre_irq, 0);
    check("R10", "tc_irq after write", tc_irq, 0);
    @(negedge clk);
    check("R10", "tdre_irq after transfer", tdre_irq, 1);
    wait_done();
    check("R10", "tc_irq at end", tc_irq, 1);
    tdre_ie = 1'b0;
    tc_ie   = 1'b0;
  endtask

  task automatic t_loop();
    // normal: receiver follows the receive pin
    rxd_i = 1'b0;
    repeat (2) @(negedge clk);
    check("R12", "rx_src from rxd_i low", rx_src, 0);
    rxd_i = 1'b1;
    repeat (2) @(negedge clk);
    check("R12", "rx_src from rxd_i high", rx_src, 1);
    // internal loop: rxd_i ignored, follows transmitter
    loop_en = 1'b1; loop_sel = 1'b0; rxd_i = 1'b0;
    repeat (2) @(negedge clk);
    check("R12", "loop ignores rxd_i", rx_src, 1);
    check("R11", "loop keeps output", txd_oe, 1);
    write_char(9'h0FE);
    repeat (30) @(negedge clk);
    check("R12", "loop sees start bit", rx_src, 0);
    wait_done();
    // single-wire, pin driven
    loop_sel = 1'b1; pin_dir = 1'b1; ext_line = 1'b0;
    repeat (2) @(negedge clk);
    check("R11", "single-wire output", txd_oe, 1);
    check("R12", "single-wire idle pin", rx_src, 1);
    write_char(9'h0FE);
    repeat (30) @(negedge clk);
    check("R12", "single-wire start bit", rx_src, 0);
    wait_done();
    // single-wire, pin as input
    pin_dir = 1'b0; ext_line = 1'b0; rxd_i = 1'b1;
    repeat (2) @(negedge clk);
    check("R11", "single-wire input", txd_oe, 0);
    check("R12", "external line low", rx_src, 0);
    ext_line = 1'b1; rxd_i = 1'b0;
    repeat (2) @(negedge clk);
    check("R12", "external line high", rx_src, 1);
    loop_en = 1'b0; loop_sel = 1'b0; pin_dir = 1'b0; rxd_i = 1'b1;
    repeat (2) @(negedge clk);
    check("R11", "normal mode output", txd_oe, 1);
  endtask

  initial begin
    rst = 1'b1; wr_en = 1'b0; wr_data = '0;
    nine_bit = 1'b0; par_en = 1'b0; par_odd = 1'b0; brk_req = 1'b0;
    loop_en = 1'b0; loop_sel = 1'b0; pin_dir = 1'b0;
    tdre_ie = 1'b0; tc_ie = 1'b0; rxd_i = 1'b1; ext_line = 1'b1;
    t_reset();
    t_frame8(8'hA5);
    t_frame8(8'h3C);
    t_nine(9'h15A);
    t_nine(9'h0FF);
    t_parity(8'h07, 1'b0);
    t_parity(8'h07, 1'b1);
    t_parity(8'h03, 1'b0);
    t_back_to_back(8'h81, 8'h6E);
    t_break();
    t_irq();
    t_loop();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule